// File: doc/BRIEF.md
# Latched XOR Random Bit Whitener with Serial Output

The block turns nine free-running, unsynchronised oscillator inputs into a stream of whitened random bits and sends them on a single serial line as asynchronous 8N1 frames. Each oscillator input has its own sampling register on the system clock. The nine samples are XOR-reduced and registered a second time. The result is one raw bit per clock cycle, and nothing is ever combined on raw oscillator edges.

One random bit is taken per serial bit period, at the start of each data bit. Each sample is XORed with three things: the parity of the data bit position, a flag that flips after every transmitted byte, and the bit that was latched before it. Each new sample therefore decides whether the running output keeps its value or inverts. Together the position parity and the byte flag give a mask of 0x55 on one byte and 0xAA on the next.

Frames are sent in a repeating cycle of eight slots. The last slot of each cycle carries no data: the line is held low for a full frame time, so a receiver that has lost framing can find it again. A divider input sets the bit period in clock cycles, and an enable input pauses the whole block.

Top module: `rng_uart_whitener`

## Requirements
- R1: While reset is asserted and after it is released, tx_o is high until the first bit tick. The first frame after reset starts from slot 0, with the latched bit cleared and the byte flag at 0.
- R2: Every serial bit lasts max(baud_div_i,1) clock cycles during which en_i is high. The first bit tick comes after that many enabled cycles from reset release.
- R3: A data frame is a low start bit, then data bits 0 to 7 (LSB first), then a high stop bit.
- R4: The raw bit is the XOR of all nine osc_i inputs. Each input is registered once, and the XOR result is registered again before use.
- R5: Data bit k (k=0..7) equals the previous data bit sent, XOR the raw bit, XOR a mask bit. The mask bit is 1 when k is even and the byte flag is 0, which gives byte mask 0x55. When the byte flag is 1 the mask bit is inverted, which gives 0xAA. The previous bit is 0 right after reset.
- R6: The byte flag flips at the end of every data frame's stop bit. It does not flip after a break slot.
- R7: Slots are numbered 0 to 7, and the cycle then repeats. Slot 7 holds tx_o low for ten bit periods and latches no sample.
- R8: While en_i is low, no bit advances, tx_o holds its value and the bit timing is frozen. Timing resumes where it stopped once en_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for the whole block |
| baud_div_i | input | 16 | Bit period in clock cycles (0 treated as 1) |
| osc_i | input | 9 | Asynchronous oscillator inputs |
| tx_o | output | 1 | Serial data out, idle high |

## Verification
The bench models the running feedback bit and the byte flag by itself. It checks every data bit across frames whose raw parity differs. A design that dropped the feedback term, or that used the wrong mask phase, would break the 0x55/0xAA alternation and go wrong from the first byte. The bench runs through two full eight-slot cycles. A design that flipped the byte flag after a break slot would go wrong on the byte that follows each break. A design that put the break in the wrong slot would send data or a stop bit where the line must stay low. The bench also checks where the bit edge falls, both with an odd divider and after a long pause on en_i. An off-by-one in the divider, or a counter that kept running while disabled, would move every later sample. A reset in the middle of a frame must bring the line high and restart the slot cycle with cleared state.

// File: rtl/rng_uart_pkg.sv
package rng_uart_pkg;
  localparam int unsigned POS_W     = 4;
  localparam int unsigned DATA_BITS = 8;

  typedef logic [POS_W-1:0] pos_t;

  // position within a slot: 0 start, 1..8 data, 9 stop
  localparam pos_t POS_START = pos_t'(0);
  localparam pos_t POS_STOP  = pos_t'(DATA_BITS + 1);
endpackage

// File: rtl/osc_sampler.sv
module osc_sampler #(
  parameter int unsigned NUM_OSC = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OSC-1:0] osc_i,
  output logic               raw_o
);
  logic [NUM_OSC-1:0] osc_q;
  logic               raw_q;

  // one capture flop per oscillator, then a second stage after the xor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= '0;
      raw_q <= 1'b0;
    end else begin
      osc_q <= osc_i;
      raw_q <= ^osc_q;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import rng_uart_pkg::*;
#(
  parameter int unsigned SLOT_CNT = 8,
  localparam int unsigned SLOT_W  = $clog2(SLOT_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              raw_i,
  output logic              tx_o,
  output pos_t              pos_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              tgl_o
);
  localparam logic [SLOT_W-1:0] BRK_SLOT = SLOT_W'(SLOT_CNT - 1);

  pos_t              pos_q, pos_n, idx_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              tgl_q, rnd_q, tx_q;
  logic              brk_cur, brk_n, data_n, mask_n, samp_n;

  assign brk_cur = (slot_q == BRK_SLOT);

  always_comb begin
    if (pos_q == POS_STOP) begin
      pos_n  = POS_START;
      slot_n = brk_cur ? '0 : slot_q + 1'b1;
    end else begin
      pos_n  = pos_q + 1'b1;
      slot_n = slot_q;
    end
  end

  assign brk_n  = (slot_n == BRK_SLOT);
  assign data_n = (pos_n != POS_START) && (pos_n != POS_STOP);
  assign idx_n  = pos_n - 1'b1;
  // even bit index -> 1 while flag is clear (0x55), inverted when set (0xAA)
  assign mask_n = ~idx_n[0] ^ tgl_q;
  assign samp_n = raw_i ^ mask_n ^ rnd_q;

  // reset parks in the stop slot of the break so the first tick opens slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= POS_STOP;
      slot_q <= BRK_SLOT;
      tgl_q  <= 1'b0;
      rnd_q  <= 1'b0;
      tx_q   <= 1'b1;
    end else if (tick_i) begin
      pos_q  <= pos_n;
      slot_q <= slot_n;
      if (pos_q == POS_STOP && !brk_cur) tgl_q <= ~tgl_q;
      if (data_n && !brk_n)              rnd_q <= samp_n;
      if (brk_n || pos_n == POS_START)   tx_q  <= 1'b0;
      else if (pos_n == POS_STOP)        tx_q  <= 1'b1;
      else                               tx_q  <= samp_n;
    end
  end

  assign tx_o   = tx_q;
  assign pos_o  = pos_q;
  assign slot_o = slot_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/rng_uart_whitener.sv
module rng_uart_whitener
  import rng_uart_pkg::*;
#(
  parameter int unsigned NUM_OSC  = 9,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned SLOT_CNT = 8,
  localparam int unsigned SLOT_W  = $clog2(SLOT_CNT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   baud_div_i,
  input  logic [NUM_OSC-1:0] osc_i,
  output logic               tx_o
);
  logic              raw_w, tick_w, tgl_w;
  pos_t              pos_w;
  logic [SLOT_W-1:0] slot_w;

  osc_sampler #(.NUM_OSC(NUM_OSC)) u_samp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .osc_i (osc_i),
    .raw_o (raw_w)
  );

  baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .div_i (baud_div_i),
    .tick_o(tick_w)
  );

  frame_tx #(.SLOT_CNT(SLOT_CNT)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_w),
    .raw_i (raw_w),
    .tx_o  (tx_o),
    .pos_o (pos_w),
    .slot_o(slot_w),
    .tgl_o (tgl_w)
  );
endmodule

// File: rtl/rng_uart_whitener_chk.sv
module rng_uart_whitener_chk
  import rng_uart_pkg::*;
#(
  parameter int unsigned SLOT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_i,
  input logic              tx_i,
  input pos_t              pos_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic              tgl_i
);
  localparam logic [SLOT_W-1:0] BRK = '1;

  // R8
  en_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(tx_i) && $stable(pos_i) && $stable(slot_i));

  // R2
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_i);

  // R3
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i == POS_START) |-> !tx_i);

  // R3
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i == POS_STOP && slot_i != BRK) |-> tx_i);

  // R7
  break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == BRK && pos_i != POS_STOP) |-> !tx_i);

  // R7
  break_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pos_i == POS_STOP && slot_i == BRK - 1'b1) |=> !tx_i);

  // R6
  tgl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && pos_i == POS_STOP && slot_i != BRK) |=> $stable(tgl_i));

  // R3
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_i <= POS_STOP);
endmodule

bind rng_uart_whitener rng_uart_whitener_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .tick_i(tick_w),
  .tx_i  (tx_o),
  .pos_i (pos_w),
  .slot_i(slot_w),
  .tgl_i (tgl_w)
);

// File: tb/rng_uart_whitener_bench.sv
module rng_uart_whitener_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div = 16'd8;
  logic [8:0]  osc = '0;
  logic        tx;

  int checks = 0;
  int fails  = 0;
  bit m_rnd  = 1'b0;
  bit m_tgl  = 1'b0;
  int slot_idx = 0;

  always #10 clk = ~clk;

  rng_uart_whitener u_rng_uart_whitener (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .baud_div_i(div),
    .osc_i     (osc),
    .tx_o      (tx)
  );

  localparam logic [8:0] OSC_TAB [14] = '{
    9'h1A5, 9'h0F3, 9'h100, 9'h0FF, 9'h003, 9'h155, 9'h0AA,
    9'h1FF, 9'h001, 9'h12C, 9'h07E, 9'h1C3, 9'h000, 9'h0B9
  };

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tx=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_bit();
    repeat (div) @(negedge clk);
  endtask

  // entered just after the tick that opens a slot
  task automatic run_slot(input logic [8:0] pat);
    bit raw, m;
    if (slot_idx == 7) begin
      for (int b = 0; b < 10; b++) begin
        chk(tx, 1'b0, "R7 break low");
        next_bit();
      end
    end else begin
      osc = pat;
      raw = ^pat;
      chk(tx, 1'b0, "R3 start");
      repeat (div - 1) @(negedge clk);
      chk(tx, 1'b0, "R2 start held");
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        m = ~k[0] ^ m_tgl;
        m_rnd = m_rnd ^ raw ^ m;
        chk(tx, m_rnd, "R5 data bit");
        next_bit();
      end
      chk(tx, 1'b1, "R3 stop");
      next_bit();
      m_tgl = ~m_tgl; // R6
    end
    slot_idx = (slot_idx + 1) % 8;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    int p = 0;
    repeat (3) @(negedge clk);
    chk(tx, 1'b1, "R1 reset idle");
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx, 1'b1, "R1 idle after release");
    en = 1'b1;
    repeat (int'(div) - 1) @(negedge clk);
    chk(tx, 1'b1, "R2 first tick not early");
    @(negedge clk);

    // table walk: two full slot cycles, R4 R5 R6 R7
    for (int i = 0; i < 16; i++) begin
      if (slot_idx == 7) run_slot('0);
      else begin
        run_slot(OSC_TAB[p]);
        p++;
      end
    end

    // odd divider, R2
    div = 16'd5;
    run_slot(9'h1A4);
    run_slot(9'h0F0);

    // enable pause at a slot boundary, R8
    en = 1'b0;
    for (int c = 0; c < 37; c++) begin
      @(negedge clk);
      chk(tx, 1'b0, "R8 frozen");
    end
    en = 1'b1;
    run_slot(9'h155);

    // reset mid-frame, R1
    osc = 9'h011;
    next_bit();
    next_bit();
    rst_n = 1'b0;
    #1;
    chk(tx, 1'b1, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    m_rnd = 1'b0;
    m_tgl = 1'b0;
    slot_idx = 0;
    repeat (int'(div) - 1) @(negedge clk);
    chk(tx, 1'b1, "R1 idle before first tick");
    @(negedge clk);
    run_slot(9'h0C7);
    run_slot(9'h120);

    finish_run();
  end
endmodule